// File: doc/BRIEF.md
# Partitioned SIMD adder

A 32-bit adder/subtractor whose one carry chain can be split at lane boundaries, so that a single wide word holds several independent packed elements. A two-bit mode input chooses one 32-bit lane, two 16-bit lanes or four 8-bit lanes. A one-bit op input chooses add or subtract. Every lane performs the same operation in the same cycle, and no carry crosses from one lane into the next.

The datapath is built from 8-bit slices. A small lane decoder tells each slice whether it starts a lane, which takes a fresh carry-in, or continues the lane below it, which takes the carry of its lower neighbour. Packed results and one carry flag per lane are registered and appear one cycle after an input beat marked valid.

Top module: `simd_add_top`

## Requirements
- R1: With mode_i = 2'b00, and also with the otherwise unused code 2'b11, the block works on one 32-bit lane: sum_o = a_i ± b_i modulo 2^32.
- R2: With mode_i = 2'b01 the word holds two 16-bit lanes, at bits [15:0] and [31:16]. Each lane is computed modulo 2^16, and no carry or borrow crosses bit 16.
- R3: With mode_i = 2'b10 the word holds four 8-bit lanes. Lane k occupies bits [8k+7:8k]. No carry crosses bits 8, 16 or 24.
- R4: sub_i = 1 makes every active lane compute a − b as a + ~b + 1, with the +1 entering at the low bit of each lane. sub_i = 0 makes every lane compute a + b.
- R5: carry_o[k] is the carry out of the top bit of lane k. In subtract mode this is the raw carry of a + ~b + 1, so 1 means no borrow.
- R6: Flags of lanes that do not exist in the current mode read 0. In 32-bit mode carry_o[3:1] = 0. In 16-bit mode carry_o[3:2] = 0.
- R7: Results appear exactly one clock after the input beat. out_valid_o is in_valid_i delayed by one cycle.
- R8: While in_valid_i is low, sum_o and carry_o keep their last values whatever a_i, b_i, mode_i and sub_i do.
- R9: After reset, out_valid_o, sum_o and carry_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat is valid |
| mode_i | input | 2 | Lane split: 00 32-bit, 01 2×16, 10 4×8, 11 32-bit |
| sub_i | input | 1 | 1 subtract, 0 add |
| a_i | input | 32 | Packed operand A |
| b_i | input | 32 | Packed operand B |
| out_valid_o | output | 1 | Registered result is valid |
| sum_o | output | 32 | Packed result |
| carry_o | output | 4 | Per-lane carry out, lane 0 in bit 0 |

## Verification
The bench builds the block with its default parameters: 8-bit slices, four of them. Those values make every split reachable: one lane, two lanes and four lanes, with their carry breaks at bits 8, 16 and 24. All-ones plus one, zero minus one and alternating byte patterns drive a carry or a borrow right up to each lane edge, so a leak across any edge shows up in the next lane's result. Idle gaps with changing operands exercise the hold behaviour.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  typedef enum logic [1:0] {
    MODE_W32     = 2'b00,
    MODE_W16     = 2'b01,
    MODE_W8      = 2'b10,
    MODE_W32_ALT = 2'b11
  } lane_mode_e;
endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map
  import simd_add_pkg::*;
#(
  parameter int N_SLICES = 4,
  localparam int LOG2N   = $clog2(N_SLICES),
  localparam int SH_W    = LOG2N + 1
) (
  input  lane_mode_e              mode_i,
  output logic [N_SLICES-1:0]     start_o,
  output logic [N_SLICES-1:0]     last_o,
  output logic [SH_W-1:0]         shift_o
);
  int sh;

  always_comb begin
    case (mode_i)
      MODE_W16: sh = LOG2N - 1;
      MODE_W8:  sh = 0;
      default:  sh = LOG2N;
    endcase
    shift_o = SH_W'(sh);
    for (int j = 0; j < N_SLICES; j++) begin
      start_o[j] = ((j       & ((1 << sh) - 1)) == 0);
      last_o[j]  = (((j + 1) & ((1 << sh) - 1)) == 0);
    end
  end
endmodule

// File: rtl/simd_slice_add.sv
module simd_slice_add #(
  parameter int SW = 8
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic          sub_i,
  input  logic          lane_start_i,
  input  logic          chain_ci_i,
  output logic [SW-1:0] sum_o,
  output logic          co_o
);
  logic [SW-1:0] b_eff;
  logic          ci;

  // a lane start takes the op's own carry-in and cuts the chain from below
  assign b_eff = sub_i ? ~b_i : b_i;
  assign ci    = lane_start_i ? sub_i : chain_ci_i;
  assign {co_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{SW{1'b0}}, ci};
endmodule

// File: rtl/simd_add_top.sv
module simd_add_top
  import simd_add_pkg::*;
#(
  parameter int SW       = 8,
  parameter int N_SLICES = 4,
  localparam int W       = SW * N_SLICES,
  localparam int SH_W    = $clog2(N_SLICES) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [1:0]          mode_i,
  input  logic                sub_i,
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  output logic                out_valid_o,
  output logic [W-1:0]        sum_o,
  output logic [N_SLICES-1:0] carry_o
);
  lane_mode_e          lane_mode;
  logic [N_SLICES-1:0] lane_start, lane_last, slice_co, lane_cy;
  logic [SH_W-1:0]     lane_shift;
  logic [W-1:0]        sum_d;

  assign lane_mode = lane_mode_e'(mode_i);

  simd_lane_map #(.N_SLICES(N_SLICES)) i_lane_map (
    .mode_i  (lane_mode),
    .start_o (lane_start),
    .last_o  (lane_last),
    .shift_o (lane_shift)
  );

  for (genvar g = 0; g < N_SLICES; g++) begin : g_slice
    logic chain_ci;
    if (g == 0) begin : g_lo
      assign chain_ci = 1'b0;
    end else begin : g_hi
      assign chain_ci = slice_co[g-1];
    end
    simd_slice_add #(.SW(SW)) i_slice (
      .a_i          (a_i[g*SW +: SW]),
      .b_i          (b_i[g*SW +: SW]),
      .sub_i        (sub_i),
      .lane_start_i (lane_start[g]),
      .chain_ci_i   (chain_ci),
      .sum_o        (sum_d[g*SW +: SW]),
      .co_o         (slice_co[g])
    );
  end

  // lane k flag = carry of its top slice; lanes absent in this mode stay 0
  always_comb begin
    lane_cy = '0;
    for (int j = 0; j < N_SLICES; j++) begin
      if (lane_last[j]) lane_cy[j >> int'(lane_shift)] = slice_co[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      sum_o       <= '0;
      carry_o     <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        sum_o   <= sum_d;
        carry_o <= lane_cy;
      end
    end
  end

  // reference for the lowest lane in byte mode, straight from the ports
  logic [SW:0] low_ref;
  assign low_ref = {1'b0, a_i[SW-1:0]} + {1'b0, (sub_i ? ~b_i[SW-1:0] : b_i[SW-1:0])}
                 + {{SW{1'b0}}, sub_i};

  // R7
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(sum_o) && $stable(carry_o)));

  // R6
  unused_w32_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (lane_mode == MODE_W32 || lane_mode == MODE_W32_ALT))
      |=> (carry_o[N_SLICES-1:1] == '0));

  // R6
  unused_w16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && lane_mode == MODE_W16) |=> (carry_o[N_SLICES-1:N_SLICES/2] == '0));

  // R3
  byte_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && lane_mode == MODE_W8)
      |=> ({carry_o[0], sum_o[SW-1:0]} == $past(low_ref)));
endmodule

// File: tb/test_simd_add_top.sv
`timescale 1ns/1ps
module test_simd_add_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sub = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        out_valid;
  logic [31:0] sum;
  logic [3:0]  carry;

  int vectors = 0;
  int fails   = 0;

  typedef struct {
    logic [31:0] sum;
    logic [3:0]  cy;
    string       req;
  } exp_t;
  exp_t q[$];
  logic [31:0] last_sum = '0;
  logic [3:0]  last_cy  = '0;

  always #4 clk = ~clk;

  simd_add_top i_simd_add_top (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .mode_i(mode),
    .sub_i(sub), .a_i(a), .b_i(b), .out_valid_o(out_valid),
    .sum_o(sum), .carry_o(carry)
  );

  function automatic void model(input logic [1:0] m, input logic s,
                                input logic [31:0] x, input logic [31:0] y,
                                output logic [31:0] r, output logic [3:0] c);
    int w;
    longint unsigned msk, ea, eb, t;
    w = (m == 2'b10) ? 8 : (m == 2'b01) ? 16 : 32;
    msk = (64'd1 << w) - 1;
    r = '0; c = '0;
    for (int k = 0; k < 32 / w; k++) begin
      ea = (longint'(x) >> (k * w)) & msk;
      eb = (longint'(y) >> (k * w)) & msk;
      if (s) eb = (~eb) & msk;
      t = ea + eb + (s ? 64'd1 : 64'd0);
      r = r | 32'((t & msk) << (k * w));
      c[k] = t[w];
    end
  endfunction

  task automatic send(input logic [1:0] m, input logic s,
                      input logic [31:0] x, input logic [31:0] y, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; mode = m; sub = s; a = x; b = y;
    model(m, s, x, y, e.sum, e.cy);
    e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; a = $urandom; b = $urandom; mode = 2'($urandom); sub = 1'($urandom);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        vectors++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R7 unexpected result sum %h cy %b expected none", sum, carry);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (sum !== e.sum || carry !== e.cy) begin
            fails++;
            $display("FAIL %s sum %h cy %b expected sum %h cy %b", e.req, sum, carry, e.sum, e.cy);
          end
          last_sum = sum; last_cy = carry;
        end
      end else begin
        vectors++;
        if (sum !== last_sum || carry !== last_cy) begin
          fails++;
          $display("FAIL R8 hold sum %h cy %b expected sum %h cy %b", sum, carry, last_sum, last_cy);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired, got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #20;
    vectors++;
    if (out_valid !== 1'b0 || sum !== '0 || carry !== '0) begin
      fails++;
      $display("FAIL R9 reset v %b sum %h cy %b expected 0 0 0", out_valid, sum, carry);
    end
    @(negedge clk); rst_n = 1'b1;
    // R1: full-width carry ripple, both encodings
    send(2'b00, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, "R1");
    send(2'b11, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, "R1");
    send(2'b00, 1'b0, 32'h00FF_FFFF, 32'h0000_0001, "R1");
    // R2: carry must stop at bit 16
    send(2'b01, 1'b0, 32'h0000_FFFF, 32'h0000_0001, "R2");
    send(2'b01, 1'b0, 32'hFFFF_FFFF, 32'h0001_0001, "R2");
    // R3: carry must stop at bits 8, 16, 24
    send(2'b10, 1'b0, 32'hFFFF_FFFF, 32'h0101_0101, "R3");
    send(2'b10, 1'b0, 32'h00FF_00FF, 32'h0001_0001, "R3");
    // R4/R5: borrow at each lane, raw carry means no borrow
    send(2'b00, 1'b1, 32'h0000_0000, 32'h0000_0001, "R4");
    send(2'b01, 1'b1, 32'h0000_0000, 32'h0001_0001, "R4");
    send(2'b10, 1'b1, 32'h0000_0000, 32'h0101_0101, "R4");
    send(2'b10, 1'b1, 32'h5050_5050, 32'h1010_1010, "R5");
    send(2'b11, 1'b1, 32'h8000_0000, 32'h8000_0000, "R5");
    // R6: unused lane flags zero even with all carries set
    send(2'b00, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    send(2'b01, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    // R8: idle gap with changing inputs
    idle(4);
    send(2'b10, 1'b0, 32'h80FF_7F01, 32'h8001_81FF, "R3");
    idle(3);
    // R7: back-to-back then mixed random traffic
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
      send(2'($urandom), 1'($urandom), $urandom, $urandom, "R7");
    end
    idle(4);
    vectors++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R7 pending results %0d expected 0", q.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule